// File: doc/BRIEF.md
# T1/E1 Backplane Timeslot Mapper

This block sits between a T1 elastic store and a serial backplane that runs one bit per clock. In the 2.048 MHz rate it spreads the 24 T1 channels across a 32-slot backplane frame. Every fourth slot, counted from slot 0, is a filler slot. On the receive path the mapper shifts T1 channel bytes out onto the backplane and drives the filler slots to all ones. The one exception is the first bit of slot 0, which carries the T1 framing bit. On the transmit path it collects the channel bits from the backplane and skips the filler slots. It can also capture the first bit of slot 0 as the outgoing framing bit. A channel-block output marks the filler slots. In the 1.544 MHz rate no filler is inserted: the frame is 193 bits long, with the framing bit first and then the 24 channel bytes.

A free-running position counter defines the frame. It is restarted by the frame sync pulse. Channel bytes enter on a valid/ready stream with one byte of storage. The mapper raises `rx_s_ready` only while that byte buffer is empty. The next T1 channel slot takes whatever byte is held, and a slot that finds the buffer empty sends all ones. Received channel bytes leave on a second valid/ready stream, each tagged with its channel index. The sink must accept each byte before the next channel completes, 8 cycles later. A byte that is still unaccepted at that point is replaced by the newer one, and `tx_m_valid` stays high.

Top module: `t1e1_slot_mapper`

## Requirements
- R1: The position counter advances once per clock. In the cycle where `fsync` is high, and in the first cycle after reset, the position is the frame's first bit. Without `fsync` the counter wraps by itself after 256 bits (2.048 MHz) or 193 bits (1.544 MHz). Serial outputs show the effect of a position one cycle later.
- R2: In the 2.048 MHz rate a frame is 32 slots of 8 bits. Slots whose index is a multiple of 4 (0, 4, …, 28) are filler. T1 channel n (numbered 0 to 23 on the ports) uses the (n+1)-th non-filler slot in ascending order.
- R3: On receive, every bit of a filler slot is 1, except bit 0 of slot 0.
- R4: On receive, bit 0 of the frame (the MSB of slot 0 in the 2.048 MHz rate, position 0 in the 1.544 MHz rate) equals `rx_fbit` as sampled at that position.
- R5: `chan_blk` is 1 for all 8 bits of every filler slot in the 2.048 MHz rate, and 0 otherwise. It is always 0 in the 1.544 MHz rate.
- R6: `rx_s_ready` is 1 exactly when the one-byte buffer is empty. An accepted byte is sent in the next T1 channel slot, MSB first.
- R7: A T1 channel slot that begins while the buffer is empty sends 8'hFF.
- R8: On transmit, filler-slot bits are ignored. The 8 bits of each T1 channel slot, the first received taken as the MSB, appear on `tx_m_data` together with its index on `tx_m_chan`. `tx_m_valid` rises in the cycle after the slot's last bit.
- R9: With `tx_fbit_sel` = 1, the backplane bit at frame position 0 is loaded into `tx_fbit`, and `tx_fbit_stb` pulses for one cycle after that position. With `tx_fbit_sel` = 0 there is no pulse and `tx_fbit` keeps its value.
- R10: In the 1.544 MHz rate (`rate_e1` = 0) the frame is 193 bits: position 0 is the framing bit, and position 1 + 8n + b is bit b (MSB first) of channel n. No filler exists.
- R11: `tx_m_valid` stays high until `tx_m_ready` is seen. While it waits, `tx_m_data` holds unless a newer channel byte completes, and the newer byte replaces it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Backplane bit clock |
| rst | input | 1 | Synchronous active-high reset |
| rate_e1 | input | 1 | 1: 32-slot 2.048 MHz frame, 0: 193-bit 1.544 MHz frame |
| fsync | input | 1 | Frame sync pulse, marks the frame's first bit |
| tx_fbit_sel | input | 1 | Capture backplane position 0 as the transmit framing bit |
| rx_fbit | input | 1 | Receive framing bit to place at position 0 |
| rx_s_valid | input | 1 | Receive channel byte valid |
| rx_s_ready | output | 1 | One-byte buffer empty |
| rx_s_data | input | 8 | Receive channel byte |
| rx_ser | output | 1 | Serial backplane data out |
| chan_blk | output | 1 | High during filler slots |
| tx_ser | input | 1 | Serial backplane data in |
| tx_m_valid | output | 1 | Transmit channel byte valid |
| tx_m_ready | input | 1 | Transmit sink accepts byte |
| tx_m_data | output | 8 | Transmit channel byte |
| tx_m_chan | output | 5 | T1 channel index of `tx_m_data` |
| tx_fbit | output | 1 | Captured transmit framing bit |
| tx_fbit_stb | output | 1 | Pulse when `tx_fbit` is loaded |

## Verification
The bench drives both rates with an arithmetic channel pattern. In that pattern every channel byte depends on the frame number and the channel index, so a slot mapped to the wrong channel, or a bit-order swap, gives a different byte. Noise bits in the filler slots separate "ignored" from "absorbed". Frame-bit values that alternate across frames show whether position 0 is routed or merely constant. Gaps in the receive stream cause underruns that must send all ones. A stalled transmit sink shows the hold and replace rule. A sync pulse in mid-frame, and a run of frames without sync, tell a restart apart from a free-running wrap.

// File: rtl/t1e1_map_pkg.sv
package t1e1_map_pkg;
  typedef enum logic [1:0] {
    SK_FBIT = 2'd0,
    SK_FILL = 2'd1,
    SK_CHAN = 2'd2
  } slot_kind_e;
endpackage

// File: rtl/t1e1_frame_timer.sv
module t1e1_frame_timer
  import t1e1_map_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int BP_SLOTS    = 32,
  parameter int T1_CH       = 24,
  parameter int FILL_STRIDE = 4,
  localparam int SLOT_W     = $clog2(BP_SLOTS),
  localparam int BIT_W      = $clog2(BYTE_W),
  localparam int CH_W       = $clog2(T1_CH)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rate_e1,
  input  logic            fsync,
  output slot_kind_e      kind,
  output logic [CH_W-1:0] chan_idx,
  output logic            chan_start,
  output logic            chan_end
);
  localparam logic [BIT_W-1:0]  BIT_LAST  = BIT_W'(BYTE_W - 1);
  localparam logic [SLOT_W-1:0] E1_LAST   = SLOT_W'(BP_SLOTS - 1);
  localparam logic [SLOT_W-1:0] T1_LAST   = SLOT_W'(T1_CH - 1);
  localparam logic [SLOT_W-1:0] STRIDE    = SLOT_W'(FILL_STRIDE);

  logic              first_q;
  logic              fph_q, fph_c;
  logic [SLOT_W-1:0] slot_q, slot_c;
  logic [BIT_W-1:0]  bit_q, bit_c;
  logic [CH_W-1:0]   chan_q, chan_c;
  logic              frame_start;

  // position of the current cycle, derived from the previous one
  always_comb begin
    fph_c  = 1'b0;
    slot_c = slot_q;
    bit_c  = bit_q;
    if (first_q || fsync) begin
      fph_c  = !rate_e1;
      slot_c = '0;
      bit_c  = '0;
    end else if (!rate_e1) begin
      if (fph_q) begin
        slot_c = '0;
        bit_c  = '0;
      end else if (bit_q == BIT_LAST) begin
        bit_c = '0;
        if (slot_q >= T1_LAST) begin
          fph_c  = 1'b1;
          slot_c = '0;
        end else begin
          slot_c = slot_q + 1'b1;
        end
      end else begin
        bit_c = bit_q + 1'b1;
      end
    end else begin
      if (bit_q == BIT_LAST) begin
        bit_c  = '0;
        slot_c = (slot_q == E1_LAST) ? '0 : slot_q + 1'b1;
      end else begin
        bit_c = bit_q + 1'b1;
      end
    end
  end

  always_comb begin
    if (!rate_e1) begin
      kind = fph_c ? SK_FBIT : SK_CHAN;
    end else if (slot_c == '0 && bit_c == '0) begin
      kind = SK_FBIT;
    end else if ((slot_c % STRIDE) == '0) begin
      kind = SK_FILL;
    end else begin
      kind = SK_CHAN;
    end
    frame_start = first_q || fsync || (kind == SK_FBIT);
    chan_c      = frame_start ? '0 : chan_q;
    chan_start  = (kind == SK_CHAN) && (bit_c == '0);
    chan_end    = (kind == SK_CHAN) && (bit_c == BIT_LAST);
  end

  assign chan_idx = chan_c;

  always_ff @(posedge clk) begin
    if (rst) begin
      first_q <= 1'b1;
      fph_q   <= 1'b0;
      slot_q  <= '0;
      bit_q   <= '0;
      chan_q  <= '0;
    end else begin
      first_q <= 1'b0;
      fph_q   <= fph_c;
      slot_q  <= slot_c;
      bit_q   <= bit_c;
      chan_q  <= chan_end ? chan_c + 1'b1 : chan_c;
    end
  end
endmodule

// File: rtl/t1e1_rx_inserter.sv
module t1e1_rx_inserter
  import t1e1_map_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rate_e1,
  input  slot_kind_e        kind,
  input  logic              chan_start,
  input  logic              fbit_in,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [BYTE_W-1:0] s_data,
  output logic              ser_out,
  output logic              blk_out
);
  logic [BYTE_W-1:0] hold_q;
  logic              full_q;
  logic [BYTE_W-1:0] sh_q;
  logic [BYTE_W-1:0] load_v;

  assign s_ready = !full_q;
  assign load_v  = full_q ? hold_q : '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
      full_q <= 1'b0;
    end else if (s_valid && s_ready) begin
      hold_q <= s_data;
      full_q <= 1'b1;
    end else if (chan_start) begin
      full_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q    <= '1;
      ser_out <= 1'b1;
      blk_out <= 1'b0;
    end else begin
      blk_out <= (kind == SK_FILL) || (kind == SK_FBIT && rate_e1);
      unique case (kind)
        SK_FBIT: ser_out <= fbit_in;
        SK_FILL: ser_out <= 1'b1;
        default: begin
          if (chan_start) begin
            ser_out <= load_v[BYTE_W-1];
            sh_q    <= {load_v[BYTE_W-2:0], 1'b1};
          end else begin
            ser_out <= sh_q[BYTE_W-1];
            sh_q    <= {sh_q[BYTE_W-2:0], 1'b1};
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/t1e1_tx_extractor.sv
module t1e1_tx_extractor
  import t1e1_map_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int CH_W   = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  slot_kind_e        kind,
  input  logic              chan_end,
  input  logic [CH_W-1:0]   chan_idx,
  input  logic              ser_in,
  input  logic              fbit_sel,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [BYTE_W-1:0] m_data,
  output logic [CH_W-1:0]   m_chan,
  output logic              fbit_out,
  output logic              fbit_stb
);
  logic [BYTE_W-1:0] acc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      m_valid <= 1'b0;
      m_data  <= '0;
      m_chan  <= '0;
    end else begin
      if (kind == SK_CHAN) begin
        acc_q <= {acc_q[BYTE_W-2:0], ser_in};
      end
      if (chan_end) begin
        m_valid <= 1'b1;
        m_data  <= {acc_q[BYTE_W-2:0], ser_in};
        m_chan  <= chan_idx;
      end else if (m_valid && m_ready) begin
        m_valid <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fbit_out <= 1'b0;
      fbit_stb <= 1'b0;
    end else begin
      fbit_stb <= (kind == SK_FBIT) && fbit_sel;
      if ((kind == SK_FBIT) && fbit_sel) begin
        fbit_out <= ser_in;
      end
    end
  end
endmodule

// File: rtl/t1e1_slot_mapper.sv
module t1e1_slot_mapper
  import t1e1_map_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int BP_SLOTS    = 32,
  parameter int T1_CH       = 24,
  parameter int FILL_STRIDE = 4,
  localparam int CH_W       = $clog2(T1_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rate_e1,
  input  logic              fsync,
  input  logic              tx_fbit_sel,
  input  logic              rx_fbit,
  input  logic              rx_s_valid,
  output logic              rx_s_ready,
  input  logic [BYTE_W-1:0] rx_s_data,
  output logic              rx_ser,
  output logic              chan_blk,
  input  logic              tx_ser,
  output logic              tx_m_valid,
  input  logic              tx_m_ready,
  output logic [BYTE_W-1:0] tx_m_data,
  output logic [CH_W-1:0]   tx_m_chan,
  output logic              tx_fbit,
  output logic              tx_fbit_stb
);
  slot_kind_e      kind;
  logic [CH_W-1:0] chan_idx;
  logic            chan_start;
  logic            chan_end;

  t1e1_frame_timer #(
    .BYTE_W(BYTE_W), .BP_SLOTS(BP_SLOTS), .T1_CH(T1_CH), .FILL_STRIDE(FILL_STRIDE)
  ) u_timer (
    .clk(clk), .rst(rst), .rate_e1(rate_e1), .fsync(fsync),
    .kind(kind), .chan_idx(chan_idx), .chan_start(chan_start), .chan_end(chan_end)
  );

  t1e1_rx_inserter #(.BYTE_W(BYTE_W)) u_rx (
    .clk(clk), .rst(rst), .rate_e1(rate_e1), .kind(kind), .chan_start(chan_start),
    .fbit_in(rx_fbit), .s_valid(rx_s_valid), .s_ready(rx_s_ready), .s_data(rx_s_data),
    .ser_out(rx_ser), .blk_out(chan_blk)
  );

  t1e1_tx_extractor #(.BYTE_W(BYTE_W), .CH_W(CH_W)) u_tx (
    .clk(clk), .rst(rst), .kind(kind), .chan_end(chan_end), .chan_idx(chan_idx),
    .ser_in(tx_ser), .fbit_sel(tx_fbit_sel), .m_valid(tx_m_valid), .m_ready(tx_m_ready),
    .m_data(tx_m_data), .m_chan(tx_m_chan), .fbit_out(tx_fbit), .fbit_stb(tx_fbit_stb)
  );
endmodule

// File: rtl/t1e1_slot_mapper_chk.sv
module t1e1_slot_mapper_chk
  import t1e1_map_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int T1_CH  = 24,
  parameter int CH_W   = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              rate_e1,
  input logic              fsync,
  input logic              tx_fbit_sel,
  input logic              rx_fbit,
  input logic              rx_s_valid,
  input logic              rx_s_ready,
  input logic              rx_ser,
  input logic              chan_blk,
  input logic              tx_m_valid,
  input logic              tx_m_ready,
  input logic [BYTE_W-1:0] tx_m_data,
  input logic              tx_fbit,
  input logic              tx_fbit_stb,
  input slot_kind_e        kind,
  input logic [CH_W-1:0]   chan_idx,
  input logic              chan_start,
  input logic              chan_end
);
  a_r1_sync_starts_frame: assert property (@(posedge clk) disable iff (rst)
    fsync |-> kind == SK_FBIT);

  a_r2_chan_in_range: assert property (@(posedge clk) disable iff (rst)
    (kind == SK_CHAN) |-> chan_idx < CH_W'(T1_CH));

  a_r3_filler_ones: assert property (@(posedge clk) disable iff (rst)
    (kind == SK_FILL) |=> rx_ser);

  a_r4_fbit_routed: assert property (@(posedge clk) disable iff (rst)
    (kind == SK_FBIT) |=> rx_ser == $past(rx_fbit));

  a_r5_no_blk_t1: assert property (@(posedge clk) disable iff (rst)
    !rate_e1 |=> !chan_blk);

  a_r6_accept_fills: assert property (@(posedge clk) disable iff (rst)
    (rx_s_valid && rx_s_ready) |=> !rx_s_ready);

  a_r7_underrun_ones: assert property (@(posedge clk) disable iff (rst)
    (chan_start && rx_s_ready) |=> rx_ser);

  a_r8_byte_out: assert property (@(posedge clk) disable iff (rst)
    chan_end |=> tx_m_valid);

  a_r9_stb_needs_sel: assert property (@(posedge clk) disable iff (rst)
    tx_fbit_stb |-> $past(tx_fbit_sel));

  a_r9_fbit_holds: assert property (@(posedge clk) disable iff (rst)
    !tx_fbit_stb |-> $stable(tx_fbit));

  a_r11_valid_held: assert property (@(posedge clk) disable iff (rst)
    (tx_m_valid && !tx_m_ready) |=> tx_m_valid);

  a_r11_data_held: assert property (@(posedge clk) disable iff (rst)
    (tx_m_valid && !tx_m_ready && !chan_end) |=> $stable(tx_m_data));
endmodule

bind t1e1_slot_mapper t1e1_slot_mapper_chk #(
  .BYTE_W(BYTE_W), .T1_CH(T1_CH), .CH_W(CH_W)
) u_chk (
  .clk(clk), .rst(rst), .rate_e1(rate_e1), .fsync(fsync), .tx_fbit_sel(tx_fbit_sel),
  .rx_fbit(rx_fbit), .rx_s_valid(rx_s_valid), .rx_s_ready(rx_s_ready), .rx_ser(rx_ser),
  .chan_blk(chan_blk), .tx_m_valid(tx_m_valid), .tx_m_ready(tx_m_ready),
  .tx_m_data(tx_m_data), .tx_fbit(tx_fbit), .tx_fbit_stb(tx_fbit_stb),
  .kind(kind), .chan_idx(chan_idx), .chan_start(chan_start), .chan_end(chan_end)
);

// File: tb/t1e1_slot_mapper_tb.sv
`timescale 1ns/1ps
module t1e1_slot_mapper_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst = 1'b1;
  logic       rate_e1 = 1'b1, fsync = 1'b0, tx_fbit_sel = 1'b1, rx_fbit = 1'b0;
  logic       rx_s_valid = 1'b0, rx_s_ready;
  logic [7:0] rx_s_data = 8'h00;
  logic       rx_ser, chan_blk, tx_ser = 1'b0;
  logic       tx_m_valid, tx_m_ready = 1'b1;
  logic [7:0] tx_m_data;
  logic [4:0] tx_m_chan;
  logic       tx_fbit, tx_fbit_stb;

  t1e1_slot_mapper u_dut (
    .clk(clk), .rst(rst), .rate_e1(rate_e1), .fsync(fsync), .tx_fbit_sel(tx_fbit_sel),
    .rx_fbit(rx_fbit), .rx_s_valid(rx_s_valid), .rx_s_ready(rx_s_ready),
    .rx_s_data(rx_s_data), .rx_ser(rx_ser), .chan_blk(chan_blk), .tx_ser(tx_ser),
    .tx_m_valid(tx_m_valid), .tx_m_ready(tx_m_ready), .tx_m_data(tx_m_data),
    .tx_m_chan(tx_m_chan), .tx_fbit(tx_fbit), .tx_fbit_stb(tx_fbit_stb)
  );

  int checks = 0, fails = 0;
  bit done = 1'b0;

  // stimulus controls
  bit mode_e1 = 1'b1, sel = 1'b1, auto_sync = 1'b1, force_sync = 1'b0, gap = 1'b0;
  // bench model
  int  p = 0, fr = 0, acc_k = 0;
  bit  started = 1'b0, have_prev = 1'b0;
  bit  hold_full = 1'b0;
  logic [7:0] hold_v = 8'h00, cur_byte = 8'hFF;
  bit  exp_rx = 1'b1, exp_blk = 1'b0, exp_stb = 1'b0, exp_fb = 1'b0, exp_tv = 1'b0;
  logic [7:0] exp_td = 8'h00;
  int  exp_tc = 0;

  function automatic logic [7:0] rx_pat(int k);
    return 8'((k * 37 + 11) & 255);
  endfunction

  function automatic logic [7:0] tx_pat(int f, int c);
    return 8'((f * 29 + c * 7 + 3) & 255);
  endfunction

  task automatic check(string req, int act, int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (p=%0d frame=%0d)", req, act, expv, p, fr);
    end
  endtask

  task automatic do_checks();
    if (!have_prev) return;
    check("R3/R4/R6/R7/R10 rx_ser", int'(rx_ser), int'(exp_rx));
    check("R5 chan_blk", int'(chan_blk), int'(exp_blk));
    check("R9 tx_fbit_stb", int'(tx_fbit_stb), int'(exp_stb));
    check("R9 tx_fbit", int'(tx_fbit), int'(exp_fb));
    check("R8/R11 tx_m_valid", int'(tx_m_valid), int'(exp_tv));
    if (exp_tv) begin
      check("R2/R8 tx_m_data", int'(tx_m_data), int'(exp_td));
      check("R2/R8 tx_m_chan", int'(tx_m_chan), exp_tc);
    end
    check("R6 rx_s_ready", int'(rx_s_ready), int'(!hold_full));
  endtask

  task automatic drive_next();
    int len, np, chan, bitn, slot;
    bit fs, is_f, is_fill, is_chan, tbit;
    len = mode_e1 ? 256 : 193;
    np  = (!started || p + 1 >= len) ? 0 : p + 1;
    fs  = force_sync || (auto_sync && np == 0 && started);
    if (fs) np = 0;
    p = np;
    started = 1'b1;
    if (p == 0) fr++;
    // decode position
    is_f = (p == 0);
    is_fill = 1'b0; chan = 0; bitn = 0;
    if (mode_e1) begin
      slot = p / 8; bitn = p % 8;
      is_fill = !is_f && (slot % 4 == 0);
      chan = slot - slot / 4 - 1;
    end else if (!is_f) begin
      chan = (p - 1) / 8; bitn = (p - 1) % 8;
    end
    is_chan = !is_f && !is_fill;
    // transmit stimulus
    if (is_chan) tbit = tx_pat(fr, chan)[7 - bitn];
    else if (is_f) tbit = fr[0];
    else tbit = ((p * 13 + fr) % 3) == 0;
    fsync       = fs;
    rate_e1     = mode_e1;
    tx_fbit_sel = sel;
    tx_ser      = tbit;
    rx_fbit     = fr[1];
    rx_s_valid  = !(gap && p >= 40 && p < 70);
    rx_s_data   = rx_pat(acc_k);
    tx_m_ready  = !(gap && p >= 100 && p < 140);
    // receive expectation
    if (is_f) exp_rx = fr[1];
    else if (is_fill) exp_rx = 1'b1;
    else begin
      if (bitn == 0) begin
        cur_byte  = hold_full ? hold_v : 8'hFF;
        hold_full = 1'b0;
      end
      exp_rx = cur_byte[7 - bitn];
    end
    if (rx_s_valid && rx_s_ready) begin
      hold_v = rx_s_data; hold_full = 1'b1; acc_k++;
    end
    exp_blk = mode_e1 && (is_f || is_fill);
    exp_stb = is_f && sel;
    if (exp_stb) exp_fb = tbit;
    if (is_chan && bitn == 7) begin
      exp_tv = 1'b1; exp_td = tx_pat(fr, chan); exp_tc = chan;
    end else if (exp_tv && tx_m_ready) begin
      exp_tv = 1'b0;
    end
    have_prev = 1'b1;
  endtask

  task automatic cyc();
    @(negedge clk);
    do_checks();
    drive_next();
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check("R1 reset rx_ser", int'(rx_ser), 1);
    check("R5 reset chan_blk", int'(chan_blk), 0);
    check("R8 reset tx_m_valid", int'(tx_m_valid), 0);
    check("R9 reset tx_fbit_stb", int'(tx_fbit_stb), 0);
    check("R6 reset rx_s_ready", int'(rx_s_ready), 1);
    rst = 1'b0;
    drive_next();
    // 2.048 MHz rate, framing bit captured
    run(2 * 256);
    // framing bit not captured, stream gaps and sink stall
    sel = 1'b0; gap = 1'b1;
    run(256);
    gap = 1'b0; sel = 1'b1;
    while (p != 99) cyc();
    // R1: mid-frame restart, then free-running wrap
    force_sync = 1'b1; cyc(); force_sync = 1'b0;
    auto_sync = 1'b0;
    run(300);
    auto_sync = 1'b1;
    run(256);
    // R10: 1.544 MHz rate
    mode_e1 = 1'b0; force_sync = 1'b1; cyc(); force_sync = 1'b0;
    run(2 * 193);
    sel = 1'b0; gap = 1'b1;
    run(193);
    gap = 1'b0; sel = 1'b1;
    run(193);
    // back to 2.048 MHz
    mode_e1 = 1'b1; force_sync = 1'b1; cyc(); force_sync = 1'b0;
    run(260);
    @(negedge clk);
    do_checks();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 200000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule